// File: doc/BRIEF.md
# Cascadable Parity Checker with Latched Error

This block sits behind the data register of a registered address/command buffer. Each clock it captures a data word. It computes the parity of a configuration-dependent subset of the captured bits and combines that parity with a parity bit that arrives one or two clocks after its data. From this it produces two outputs: a partial-parity output, and an active-low error flag that stays asserted for a minimum hold time.

The block has three configurations. As a single device it checks its own data. As the first device of a cascaded pair it forwards its partial parity to the second device. The second device sees that parity one clock later than its own data, re-aligns it, and makes the final decision. When both chip-select inputs are high, the block freezes: the data register, the parity pipeline, the partial-parity output, the error flag and its hold counter all keep their values. An active-low asynchronous reset clears everything.

Top module: `srb_par_check`

## Requirements
- R1: While rst_n is low, q_out is 0, part_par_o is 0 and err_n_o is 1. Asserting rst_n takes effect without waiting for a clock edge.
- R2: On every rising edge that is not frozen, q_out takes the value of d_in.
- R3: When cs0_n and cs1_n are both high at an edge, q_out, part_par_o and err_n_o keep their values across that edge.
- R4: The checked bit positions of d_in depend on the configuration. With cfg_pair=0 they are bits 1, 2, 4, 5 and 7..24. With cfg_pair=1, cfg_second=0 they are bits 1, 2, 4, 5 and 7..13. With cfg_pair=1, cfg_second=1 they are bits 0..5, 7, 8, 9, 11 and 12. All other bits have no effect on parity.
- R5: With cfg_second=0, for data captured at edge n, part_par_o after edge n+1 equals the parity of the checked bits XOR the parity_in value sampled at edge n+1.
- R6: With cfg_second=1, the parity of the data captured at edge n is delayed one more stage and combined with the parity_in sampled at edge n+2. part_par_o shows the result after edge n+2.
- R7: With cfg_pair=0, err_n_o goes low at the edge after part_par_o has shown 1. This is edge n+2 when cfg_second=0.
- R8: With cfg_pair=1, err_n_o goes low at the same edge at which the combined check is 1: edge n+1 when cfg_second=0, and edge n+2 when cfg_second=1.
- R9: Once err_n_o goes low, it stays low for at least two clock cycles. It returns high at the first non-frozen edge after the hold has run out with no new error.
- R10: A new error seen while err_n_o is already low restarts the two-cycle hold from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pair | input | 1 | 0: single device, 1: one device of a cascaded pair |
| cfg_second | input | 1 | 1: second device of a pair (parity arrives two clocks late) |
| cs0_n | input | 1 | Chip select, active low; freeze when both selects are high |
| cs1_n | input | 1 | Second chip select, active low |
| d_in | input | 25 | Data word to register and check |
| parity_in | input | 1 | Late parity bit for earlier data |
| q_out | output | 25 | Registered data |
| part_par_o | output | 1 | Partial parity (checked-bit parity XOR parity_in) |
| err_n_o | output | 1 | Parity error flag, active low, held at least two cycles |

## Verification
The assertions assume three things about the inputs. The configuration pins change only while rst_n is low. Reset is asserted from time zero. Every input is stable around the rising edge. The bench follows these rules: it changes cfg_pair and cfg_second only inside a reset window, holds rst_n low from the start, and drives all inputs on the falling edge. Under these conditions a freeze has a defined meaning, as does the count from a data edge to its parity edge. Random traffic uses frozen cycles at a low rate, so error holds and restarts overlap with freezes.

// File: rtl/srb_par_pkg.sv
// Package: shared constants and bit-set selection for the parity checker.
// Assumes the data word numbers bit 0 as the first data lane.
package srb_par_pkg;

    localparam int NUM_DATA  = 25;
    localparam int SOLO_BITS = 22;
    localparam int PAIR_BITS = 11;

    // Configuration, encoded as {cfg_pair, cfg_second}
    typedef enum logic [1:0] {
        MODE_SOLO   = 2'b00,
        MODE_SOLO2  = 2'b01,
        MODE_FIRST  = 2'b10,
        MODE_SECOND = 2'b11
    } par_mode_e;

    // Returns 1 when data bit k takes part in parity under mode m
    function automatic logic bit_in_set(input par_mode_e m, input int k);
        logic common;
        common = (k == 1) || (k == 2) || (k == 4) || (k == 5);
        case (m)
            MODE_SECOND: return (k <= 5) || (k >= 7 && k <= 9) || (k == 11) || (k == 12);
            MODE_FIRST:  return common || (k >= 7 && k <= 13);
            default:     return common || (k >= 7 && k <= 24);
        endcase
    endfunction

endpackage

// File: rtl/srb_mask_gen.sv
// Mask generator: builds the per-bit enable vector of checked data lanes.
// Assumes the mode inputs are static outside reset.
module srb_mask_gen
    import srb_par_pkg::*;
#(
    parameter int DATA_W = NUM_DATA
) (
    input  par_mode_e          mode,
    output logic [DATA_W-1:0]  mask
);

    // One enable per data lane, chosen by the configuration
    for (genvar k = 0; k < DATA_W; k++) begin : g_lane
        assign mask[k] = bit_in_set(mode, k);
    end

    // Check the lane count against the configuration
    always_comb begin
        if (!$isunknown(mode)) begin
            p_mask_count_r4: assert ($countones(mask) == (mode[1] ? PAIR_BITS : SOLO_BITS))
                else $error("checked lane count wrong for mode %b", mode);
        end
    end

endmodule

// File: rtl/srb_data_stage.sv
// Data stage: the input data register with chip-select freeze.
// Assumes hold is computed from inputs stable at the clock edge.
module srb_data_stage #(
    parameter int DATA_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q
);

    // Capture data unless frozen; asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= d_in;
    end

    p_freeze_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(q))
        else $error("data register moved while frozen");

endmodule

// File: rtl/srb_par_align.sv
// Parity alignment: reduces the checked data bits to one parity bit,
// optionally delays it one more stage, and merges it with the late parity
// input. Assumes two_stage is static outside reset.
module srb_par_align #(
    parameter int DATA_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              two_stage,
    input  logic [DATA_W-1:0] q,
    input  logic [DATA_W-1:0] mask,
    input  logic              parity_in,
    output logic              chk,
    output logic              part_par_o
);

    logic dpar;
    logic dpar_d1;

    // Parity of the checked lanes of the registered data
    assign dpar = ^(q & mask);

    // Choose the one- or two-stage aligned parity and merge the late bit
    assign chk = (two_stage ? dpar_d1 : dpar) ^ parity_in;

    // Pipeline stage and partial-parity register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dpar_d1    <= 1'b0;
            part_par_o <= 1'b0;
        end else if (!hold) begin
            dpar_d1    <= dpar;
            part_par_o <= chk;
        end
    end

    p_freeze_ppo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(part_par_o) && $stable(dpar_d1)))
        else $error("partial parity moved while frozen");

endmodule

// File: rtl/srb_err_hold.sv
// Error hold: drives the active-low error flag and stretches each error to
// at least HOLD_CYC cycles with a small down-counter; a new error reloads it.
// Assumes err_in is already aligned to the edge at which the flag must fall.
module srb_err_hold #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic err_in,
    output logic err_n_o
);

    localparam int CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Set on error, count down the hold, release when the count is spent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_n_o <= 1'b1;
            cnt     <= '0;
        end else if (!hold) begin
            if (err_in) begin
                err_n_o <= 1'b0;
                cnt     <= RELOAD;
            end else if (cnt != '0) begin
                cnt     <= cnt - 1'b1;
            end else begin
                err_n_o <= 1'b1;
            end
        end
    end

    p_detect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && err_in) |=> !err_n_o)
        else $error("error not flagged");

    p_hold_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n_o) |=> !err_n_o)
        else $error("error flag shorter than two cycles");

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_n_o) |-> ($past(cnt) == '0))
        else $error("error flag released with hold pending");

    p_freeze_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(err_n_o) && $stable(cnt)))
        else $error("error flag moved while frozen");

endmodule

// File: rtl/srb_par_check.sv
// Top: registered data path with configurable parity check for single or
// cascaded use. Freeze when both chip selects are high; reset is async.
// Assumes cfg_pair/cfg_second change only while rst_n is low.
module srb_par_check
    import srb_par_pkg::*;
#(
    parameter int DATA_W   = NUM_DATA,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pair,
    input  logic              cfg_second,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              parity_in,
    output logic [DATA_W-1:0] q_out,
    output logic              part_par_o,
    output logic              err_n_o
);

    par_mode_e         mode;
    logic              frz;
    logic [DATA_W-1:0] mask;
    logic              chk;
    logic              err_src;

    // Decode configuration and freeze condition
    assign mode = par_mode_e'({cfg_pair, cfg_second});
    assign frz  = cs0_n & cs1_n;

    // Pair devices flag at the check edge; single devices one edge later
    assign err_src = cfg_pair ? chk : part_par_o;

    srb_mask_gen #(.DATA_W(DATA_W)) u_mask (
        .mode (mode),
        .mask (mask)
    );

    srb_data_stage #(.DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (frz),
        .d_in  (d_in),
        .q     (q_out)
    );

    srb_par_align #(.DATA_W(DATA_W)) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (frz),
        .two_stage  (cfg_second),
        .q          (q_out),
        .mask       (mask),
        .parity_in  (parity_in),
        .chk        (chk),
        .part_par_o (part_par_o)
    );

    srb_err_hold #(.HOLD_CYC(HOLD_CYC)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (frz),
        .err_in  (err_src),
        .err_n_o (err_n_o)
    );

endmodule

// File: tb/sim_srb_par_check.sv
`timescale 1ns/1ps
module sim_srb_par_check;

    localparam int DW = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_pair = 1'b0;
    logic          cfg_second = 1'b0;
    logic          cs0_n = 1'b0;
    logic          cs1_n = 1'b0;
    logic [DW-1:0] d_in = '0;
    logic          parity_in = 1'b0;
    logic [DW-1:0] q_out;
    logic          part_par_o;
    logic          err_n_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_q;
    logic          m_dp1, m_ppo, m_err_n;
    int            m_cnt;

    srb_par_check u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pair(cfg_pair), .cfg_second(cfg_second),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .d_in(d_in), .parity_in(parity_in),
        .q_out(q_out), .part_par_o(part_par_o), .err_n_o(err_n_o)
    );

    always #4 clk = ~clk;

    // Checked lanes per configuration (R4)
    function automatic logic lane_on(input logic pair, input logic second, input int k);
        if (pair && second) return (k <= 5) || (k == 7) || (k == 8) || (k == 9) || (k == 11) || (k == 12);
        if (k == 1 || k == 2 || k == 4 || k == 5) return 1'b1;
        if (pair) return (k >= 7) && (k <= 13);
        return (k >= 7) && (k <= 24);
    endfunction

    function automatic logic par_of(input logic [DW-1:0] v, input logic pair, input logic second);
        logic r = 1'b0;
        for (int k = 0; k < DW; k++) if (lane_on(pair, second, k)) r ^= v[k];
        return r;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Apply inputs at the falling edge, advance one clock, update the model
    task automatic step(input logic [DW-1:0] d, input logic p, input logic a, input logic b);
        logic dp, chkv, errv;
        d_in = d; parity_in = p; cs0_n = a; cs1_n = b;
        @(posedge clk);
        if (!rst_n) begin
            m_q = '0; m_dp1 = 0; m_ppo = 0; m_err_n = 1; m_cnt = 0;
        end else if (!(a && b)) begin
            dp   = par_of(m_q, cfg_pair, cfg_second);
            chkv = (cfg_second ? m_dp1 : dp) ^ p;
            errv = cfg_pair ? chkv : m_ppo;
            m_ppo = chkv; m_dp1 = dp; m_q = d;
            if (errv) begin m_err_n = 0; m_cnt = 1; end
            else if (m_cnt != 0) m_cnt--;
            else m_err_n = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(); step('0, 0, 0, 0); endtask

    task automatic do_reset(input logic pair, input logic second, input bit chk_async);
        rst_n = 0; cfg_pair = pair; cfg_second = second;
        #1;
        if (chk_async) begin
            check("R1", "async q_out", q_out, 0);
            check("R1", "async part_par_o", part_par_o, 0);
            check("R1", "async err_n_o", err_n_o, 1);
        end
        step('0, 0, 0, 0);
        step('0, 0, 0, 0);
        rst_n = 1;
    endtask

    task automatic rand_run(input logic pair, input logic second, input int cycles);
        string tp, te;
        tp = second ? "R6" : "R5";
        te = pair ? "R8" : "R7";
        do_reset(pair, second, 1);
        for (int i = 0; i < cycles; i++) begin
            logic a, b;
            if ($urandom_range(0, 7) == 0) begin a = 1; b = 1; end
            else begin a = 1'($urandom_range(0, 1)); b = a ? 1'b0 : 1'($urandom_range(0, 1)); end
            step(DW'($urandom), 1'($urandom_range(0, 1)), a, b);
            check("R2", "rand q_out", q_out, m_q);
            check(tp, "rand part_par_o", part_par_o, m_ppo);
            check(te, "rand err_n_o", err_n_o, m_err_n);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        do_reset(0, 0, 0);
        check("R1", "reset q_out", q_out, 0);
        check("R1", "reset part_par_o", part_par_o, 0);
        check("R1", "reset err_n_o", err_n_o, 1);

        // Single device: one error on lane 1
        step(25'h2, 0, 0, 0);
        check("R2", "capture", q_out, 25'h2);
        check("R5", "ppo before parity edge", part_par_o, 0);
        idle();
        check("R5", "ppo at n+1", part_par_o, 1);
        check("R7", "err_n not yet at n+1", err_n_o, 1);
        idle();
        check("R7", "err_n at n+2", err_n_o, 0);
        idle();
        check("R9", "err_n held second cycle", err_n_o, 0);
        idle();
        check("R9", "err_n released", err_n_o, 1);

        // Lane 0 is not checked in single mode; parity_in cancels odd parity
        step(25'h1, 0, 0, 0);
        idle();
        check("R4", "lane 0 ignored single", part_par_o, 0);
        step(25'h2, 0, 0, 0);
        step('0, 1, 0, 0);
        check("R5", "parity_in cancels", part_par_o, 0);
        idle(); idle(); idle();
        check("R5", "quiet err_n", err_n_o, 1);

        // Restart of the hold by a second error
        step(25'h2, 0, 0, 0);
        step(25'h2, 0, 0, 0);
        step('0, 0, 0, 0);
        check("R10", "first error", err_n_o, 0);
        idle();
        check("R10", "second error", err_n_o, 0);
        idle();
        check("R10", "hold restarted", err_n_o, 0);
        idle();
        check("R10", "released after restart", err_n_o, 1);

        // Freeze
        step(25'h5, 0, 0, 0);
        step(25'h9, 1, 1, 1);
        check("R3", "q_out frozen", q_out, 25'h5);
        check("R3", "ppo frozen", part_par_o, 1'b0);
        check("R3", "err_n frozen", err_n_o, 1);
        step(25'h9, 1, 0, 1);
        check("R3", "one select low runs", q_out, 25'h9);

        // First device of a pair: flag at n+1
        do_reset(1, 0, 1);
        step(25'h2, 0, 0, 0);
        idle();
        check("R8", "first dev ppo at n+1", part_par_o, 1);
        check("R8", "first dev err_n at n+1", err_n_o, 0);
        idle(); idle(); idle();
        step(25'h4000, 0, 0, 0);
        idle();
        check("R4", "lane 14 ignored in pair", part_par_o, 0);

        // Second device of a pair: parity_in two clocks late
        do_reset(1, 1, 1);
        step(25'h1, 0, 0, 0);
        idle();
        check("R6", "second dev ppo at n+1", part_par_o, 0);
        check("R6", "second dev err_n at n+1", err_n_o, 1);
        idle();
        check("R6", "second dev ppo at n+2", part_par_o, 1);
        check("R8", "second dev err_n at n+2", err_n_o, 0);
        idle(); idle(); idle();
        step(25'h1, 0, 0, 0);
        idle();
        step('0, 1, 0, 0);
        check("R6", "late parity cancels", part_par_o, 0);

        // Random traffic in every configuration
        rand_run(0, 0, 400);
        rand_run(1, 0, 400);
        rand_run(1, 1, 400);
        rand_run(0, 1, 400);

        // Async reset from a busy state
        rst_n = 0;
        #1;
        check("R1", "async mid-run err_n", err_n_o, 1);
        check("R1", "async mid-run q_out", q_out, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule